// File: doc/BRIEF.md
# Scanned Keyboard Matrix Controller

This block drives the scan lines of a key matrix of up to eight rows by eight columns, reads the active-low return lines, and debounces a closure before taking it as a key press. Each accepted press becomes one byte holding the row, the column and the state of a shift input. That byte goes into an eight-entry first-in first-out queue. While the queue holds anything, an interrupt line to the host stays high.

The scan counter runs in one of two modes, chosen by a static mode pin. In binary mode it puts out a 3-bit row number for an external decoder. In one-hot mode it decodes the two low bits itself and drives exactly one of four select lines. The host uses a small register port with chip select, read and write strobes and one address bit. With the address bit low, a read pops the oldest key byte. With it high, a read returns the status (entry count and a sticky overrun flag), and a write clears the overrun flag.

Top module: `keyscan_ctrl`

## Requirements
- R1: In binary mode (mode pin 0) `scan_lines[2:0]` carries the row number and counts 0,1,...,7 and back to 0; `scan_lines[3]` is always 0; after reset it reads 0.
- R2: In one-hot mode (mode pin 1) exactly one bit of `scan_lines` is high, bit k for row k; rows cycle 0..3 only, so keys in rows 4..7 are never reported.
- R3: Each row stays on the scan lines for exactly DWELL clock cycles (default 4) before the next one.
- R4: A return line pulled low in the active row is taken as a press only if the same key is still closed when that row comes round again one full scan later; a closure that is gone by then is dropped.
- R5: A key byte is laid out as bit 7 = 0, bit 6 = shift input level at acceptance, bits 5:3 = row, bits 2:0 = column (lowest closed column wins).
- R6: Reads with the address bit at 0 return key bytes oldest first, one entry per read access (one clock with chip select and read strobe low).
- R7: A status read (address bit 1) returns the entry count in bits 3:0, the overrun flag in bit 5 and zeros elsewhere.
- R8: A press accepted while eight entries are unread is discarded, leaves the count at 8 and sets the overrun flag, which stays set through later reads.
- R9: A write with the address bit at 1 clears the overrun flag; a write with the address bit at 0 has no effect.
- R10: `irq` is high exactly while the queue holds at least one entry and drops when the last entry is read.
- R11: A data read from an empty queue returns 0x00 and leaves the count at 0.
- R12: A key held over many scans produces one entry only, until it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decoded_mode | input | 1 | 0 = binary row count, 1 = internal one-hot of four |
| scan_lines | output | 4 | Row select outputs |
| ret_n | input | 8 | Return lines, low when a key in the active row is closed |
| shift_in | input | 1 | Shift key level stored with each key byte |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | 0 = key data, 1 = status / clear |
| dout | output | 8 | Read data (combinational from a0 and queue state) |
| irq | output | 1 | High while key data is waiting |

## Verification
A row change shows on the scan lines one clock after the last dwell cycle. A press is accepted at the clock that ends its row's dwell one full scan (8 × DWELL cycles) after detection, so the count and `irq` change at that edge. The bench checks that the count is still 0 two cycles short of one scan period after a press, and reads it again only after two more full periods. A pop or an overrun-flag clear takes effect at the clock edge that ends the bus access. `dout` is combinational, so the bench samples it one time unit after driving the strobes, and all other samples are taken at falling edges.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  localparam int KS_COLS   = 8;
  localparam int KS_ROW_W  = 3;
  localparam int KS_COL_W  = 3;
  localparam int KS_CODE_W = 8;
  localparam int KS_SCAN_W = 4;

  typedef enum logic [1:0] {
    DB_IDLE = 2'd0,
    DB_PEND = 2'd1,
    DB_HELD = 2'd2
  } db_state_t;

  // Lowest-numbered return line that is pulled low.
  function automatic logic [KS_COL_W-1:0] first_low(input logic [KS_COLS-1:0] r_n);
    logic [KS_COL_W-1:0] idx;
    idx = '0;
    for (int i = KS_COLS - 1; i >= 0; i--) begin
      if (!r_n[i]) idx = KS_COL_W'(i);
    end
    return idx;
  endfunction

  // Key byte: reserved zero, shift, row, column.
  function automatic logic [KS_CODE_W-1:0] pack_code(input logic sh,
                                                     input logic [KS_ROW_W-1:0] row,
                                                     input logic [KS_COL_W-1:0] col);
    return {1'b0, sh, row, col};
  endfunction

  // One-hot select of four from the two low row bits.
  function automatic logic [KS_SCAN_W-1:0] onehot4(input logic [1:0] r);
    return KS_SCAN_W'(1) << r;
  endfunction

  // Circular pointer advance.
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/keyscan_scan_ctr.sv
module keyscan_scan_ctr
  import keyscan_pkg::*;
#(
  parameter int DWELL = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 decoded_mode,
  output logic [KS_ROW_W-1:0]  row,
  output logic                 tick,
  output logic [KS_SCAN_W-1:0] scan_lines
);

  localparam int DW_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

  logic [DW_W-1:0]     dcnt;
  logic [KS_ROW_W-1:0] last_row;

  assign tick     = (dcnt == DW_LAST);
  assign last_row = decoded_mode ? KS_ROW_W'(3) : KS_ROW_W'(7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      row  <= '0;
    end else if (tick) begin
      dcnt <= '0;
      row  <= (row >= last_row) ? '0 : row + 1'b1;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_comb begin
    if (decoded_mode) scan_lines = onehot4(row[1:0]);
    else              scan_lines = {1'b0, row};
  end

endmodule

// File: rtl/keyscan_debounce.sv
module keyscan_debounce
  import keyscan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [KS_ROW_W-1:0]  row,
  input  logic [KS_COLS-1:0]   ret_n,
  input  logic                 shift_in,
  output logic                 push,
  output logic [KS_CODE_W-1:0] code,
  output db_state_t            state
);

  logic [KS_ROW_W-1:0] krow;
  logic [KS_COL_W-1:0] kcol;
  logic                at_krow;
  logic                kclosed;
  logic                any_low;

  assign at_krow = tick && (row == krow);
  assign kclosed = !ret_n[kcol];
  assign any_low = !(&ret_n);
  assign push    = at_krow && (state == DB_PEND) && kclosed;
  assign code    = pack_code(shift_in, krow, kcol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= DB_IDLE;
      krow  <= '0;
      kcol  <= '0;
    end else begin
      unique case (state)
        DB_IDLE: if (tick && any_low) begin
          krow  <= row;
          kcol  <= first_low(ret_n);
          state <= DB_PEND;
        end
        DB_PEND: if (at_krow) state <= kclosed ? DB_HELD : DB_IDLE;
        DB_HELD: if (at_krow && !kclosed) state <= DB_IDLE;
        default: state <= DB_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/keyscan_fifo.sv
module keyscan_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  input  logic                         clr_ovf,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         ovf
);
  import keyscan_pkg::ptr_next;

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             empty, do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign head  = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_wr) wptr <= PTR_W'(ptr_next(int'(wptr), DEPTH));
      if (do_rd) rptr <= PTR_W'(ptr_next(int'(rptr), DEPTH));
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
  import keyscan_pkg::*;
#(
  parameter int DWELL = 4,
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        decoded_mode,
  output logic [3:0]  scan_lines,
  input  logic [7:0]  ret_n,
  input  logic        shift_in,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        a0,
  output logic [7:0]  dout,
  output logic        irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // Named internal events, also seen by the bound checker.
  logic                 scan_tick;
  logic [KS_ROW_W-1:0]  scan_row;
  logic                 key_push;
  logic [KS_CODE_W-1:0] key_code;
  db_state_t            db_state;
  logic                 host_pop;
  logic                 host_clr;
  logic [CNT_W-1:0]     fifo_count;
  logic                 fifo_full;
  logic                 fifo_ovf;
  logic [KS_CODE_W-1:0] fifo_head;
  logic [3:0]           cnt_field;
  logic [7:0]           status;

  keyscan_scan_ctr #(.DWELL(DWELL)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .decoded_mode (decoded_mode),
    .row          (scan_row),
    .tick         (scan_tick),
    .scan_lines   (scan_lines)
  );

  keyscan_debounce u_db (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (scan_tick),
    .row      (scan_row),
    .ret_n    (ret_n),
    .shift_in (shift_in),
    .push     (key_push),
    .code     (key_code),
    .state    (db_state)
  );

  assign host_pop = !cs_n && !rd_n && !a0;
  assign host_clr = !cs_n && !wr_n && a0;

  keyscan_fifo #(.DEPTH(DEPTH), .W(KS_CODE_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (key_push),
    .din     (key_code),
    .pop     (host_pop),
    .clr_ovf (host_clr),
    .head    (fifo_head),
    .count   (fifo_count),
    .full    (fifo_full),
    .ovf     (fifo_ovf)
  );

  assign cnt_field = 4'(fifo_count);
  assign status    = {2'b00, fifo_ovf, 1'b0, cnt_field};
  assign dout      = cs_n ? 8'h00 : (a0 ? status : fifo_head);
  assign irq       = (fifo_count != '0);

endmodule

// File: rtl/keyscan_ctrl_chk.sv
module keyscan_ctrl_chk #(
  parameter int DEPTH = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        decoded_mode,
  input logic [3:0]                  scan_lines,
  input logic                        scan_tick,
  input logic                        key_push,
  input logic [7:0]                  key_code,
  input logic                        host_pop,
  input logic                        host_clr,
  input logic [$clog2(DEPTH+1)-1:0]  fifo_count,
  input logic                        fifo_full,
  input logic                        fifo_ovf,
  input logic                        irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  a_r1_top_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !decoded_mode |-> !scan_lines[3]);

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    decoded_mode |-> $countones(scan_lines) == 1);

  a_r2_low_rows_only: assert property (@(posedge clk) disable iff (!rst_n)
    (decoded_mode && key_push) |-> !key_code[5]);

  a_r3_dwell_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(scan_lines));

  a_r5_reserved_bit: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |-> !key_code[7]);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  a_r8_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && key_push && !host_pop) |=> (fifo_count == CNT_W'(DEPTH)) && fifo_ovf);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf && !host_clr) |=> fifo_ovf);

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_clr && !(key_push && fifo_full)) |=> !fifo_ovf);

  a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && fifo_count == CNT_W'(1) && !key_push) |=> !irq);

  a_r10_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (key_push && !host_pop) |=> irq);

endmodule

bind keyscan_ctrl keyscan_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .decoded_mode (decoded_mode),
  .scan_lines   (scan_lines),
  .scan_tick    (scan_tick),
  .key_push     (key_push),
  .key_code     (key_code),
  .host_pop     (host_pop),
  .host_clr     (host_clr),
  .fifo_count   (fifo_count),
  .fifo_full    (fifo_full),
  .fifo_ovf     (fifo_ovf),
  .irq          (irq)
);

// File: tb/keyscan_ctrl_test.sv
`timescale 1ns/1ps
module keyscan_ctrl_test;

  localparam int DWELL  = 4;
  localparam int PERIOD = DWELL * 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       decoded_mode = 1'b0;
  logic [3:0] scan_lines;
  logic [7:0] ret_n;
  logic       shift_in = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [7:0] dout;
  logic       irq;

  // Matrix model: one closed key at a time.
  logic       key_on = 1'b0;
  logic [2:0] key_row = '0, key_col = '0;
  logic [2:0] cur_row;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  keyscan_ctrl #(.DWELL(DWELL), .DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .decoded_mode(decoded_mode),
    .scan_lines(scan_lines), .ret_n(ret_n), .shift_in(shift_in),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .dout(dout), .irq(irq)
  );

  always_comb begin
    if (decoded_mode) begin
      case (scan_lines)
        4'b0001: cur_row = 3'd0;
        4'b0010: cur_row = 3'd1;
        4'b0100: cur_row = 3'd2;
        4'b1000: cur_row = 3'd3;
        default: cur_row = 3'd7;
      endcase
    end else begin
      cur_row = scan_lines[2:0];
    end
    ret_n = 8'hFF;
    if (key_on && cur_row == key_row) ret_n[key_col] = 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; a0 = sel;
    #1 d = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; a0 = 1'b0;
  endtask

  task automatic bus_write(input logic sel);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; a0 = sel;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; a0 = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; decoded_mode = mode; key_on = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic press_key(input logic [2:0] r, input logic [2:0] c, input logic s);
    key_row = r; key_col = c; shift_in = s; key_on = 1'b1;
    wait_cyc(3 * PERIOD);
    key_on = 1'b0;
    wait_cyc(2 * PERIOD);
  endtask

  function automatic logic [7:0] exp_code(input logic s, input int r, input int c);
    return (8'(s) << 6) | (8'(r) << 3) | 8'(c);
  endfunction

  task automatic t_reset_state();
    logic [7:0] st;
    do_reset(1'b0);
    #1;
    check(scan_lines == 4'd0, "R1 reset scan", int'(scan_lines), 0);
    check(irq == 1'b0, "R10 reset irq", int'(irq), 0);
    bus_read(1'b1, st);
    check(st == 8'h00, "R7 reset status", int'(st), 0);
  endtask

  task automatic t_binary_scan();
    logic [3:0] prev;
    int run = 0, bad_seq = 0, bad_len = 0, bad_top = 0, changes = 0;
    do_reset(1'b0);
    prev = scan_lines;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      if (scan_lines[3]) bad_top++;
      run++;
      if (scan_lines != prev) begin
        if (scan_lines[2:0] != 3'(prev[2:0] + 3'd1)) bad_seq++;
        if (changes > 0 && run != DWELL) bad_len++;
        changes++;
        run = 0;
        prev = scan_lines;
      end
    end
    check(bad_seq == 0 && changes > 16, "R1 binary sequence", bad_seq, 0);
    check(bad_top == 0, "R1 top line low", bad_top, 0);
    check(bad_len == 0, "R3 dwell length", bad_len, 0);
  endtask

  task automatic t_debounce_timing();
    logic [7:0] st, d;
    do_reset(1'b0);
    key_row = 3'd3; key_col = 3'd1; shift_in = 1'b0; key_on = 1'b1;
    wait_cyc(PERIOD - 2);
    bus_read(1'b1, st);
    check(st[3:0] == 4'd0, "R4 not before one scan", int'(st[3:0]), 0);
    wait_cyc(2 * PERIOD);
    bus_read(1'b1, st);
    check(st[3:0] == 4'd1, "R4 accepted after scan", int'(st[3:0]), 1);
    check(irq == 1'b1, "R10 irq with data", int'(irq), 1);
    key_on = 1'b0;
    wait_cyc(2 * PERIOD);
    bus_read(1'b0, d);
    check(d == exp_code(0, 3, 1), "R5 key byte", int'(d), int'(exp_code(0, 3, 1)));
    #1;
    check(irq == 1'b0, "R10 irq drops", int'(irq), 0);
  endtask

  task automatic t_glitch();
    logic [7:0] st;
    do_reset(1'b0);
    key_row = 3'd0; key_col = 3'd4; key_on = 1'b1;
    wait_cyc(10);
    key_on = 1'b0;
    wait_cyc(3 * PERIOD);
    bus_read(1'b1, st);
    check(st[3:0] == 4'd0, "R4 bounce dropped", int'(st[3:0]), 0);
  endtask

  task automatic t_hold_shift();
    logic [7:0] st, d;
    do_reset(1'b0);
    key_row = 3'd7; key_col = 3'd6; shift_in = 1'b1; key_on = 1'b1;
    wait_cyc(6 * PERIOD);
    key_on = 1'b0;
    wait_cyc(2 * PERIOD);
    shift_in = 1'b0;
    bus_read(1'b1, st);
    check(st[3:0] == 4'd1, "R12 one entry for held key", int'(st[3:0]), 1);
    bus_read(1'b0, d);
    check(d == exp_code(1, 7, 6), "R5 shift bit stored", int'(d), int'(exp_code(1, 7, 6)));
  endtask

  task automatic t_read_empty();
    logic [7:0] d, st;
    do_reset(1'b0);
    bus_read(1'b0, d);
    check(d == 8'h00, "R11 empty read data", int'(d), 0);
    bus_read(1'b1, st);
    check(st == 8'h00, "R11 empty count", int'(st), 0);
  endtask

  task automatic t_overflow();
    logic [7:0] st, d;
    int bad = 0;
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) press_key(3'(i), 3'((i * 3) % 8), 1'(i % 2));
    bus_read(1'b1, st);
    check(st == 8'h08, "R7 full status", int'(st), 8'h08);
    press_key(3'd5, 3'd2, 1'b1);
    bus_read(1'b1, st);
    check(st == 8'h28, "R8 overrun flag and count", int'(st), 8'h28);
    bus_write(1'b0);
    bus_read(1'b1, st);
    check(st[5] == 1'b1, "R9 data write ignored", int'(st[5]), 1);
    for (int i = 0; i < 8; i++) begin
      bus_read(1'b0, d);
      if (d != exp_code(1'(i % 2), i, (i * 3) % 8)) begin
        bad++;
        $display("FAIL R6 entry %0d: actual 0x%0h expected 0x%0h",
                 i, d, exp_code(1'(i % 2), i, (i * 3) % 8));
      end
    end
    check(bad == 0, "R6 order of entries", bad, 0);
    #1;
    check(irq == 1'b0, "R10 irq after drain", int'(irq), 0);
    bus_read(1'b1, st);
    check(st == 8'h20, "R8 flag sticky after reads", int'(st), 8'h20);
    bus_write(1'b1);
    bus_read(1'b1, st);
    check(st == 8'h00, "R9 flag cleared", int'(st), 0);
  endtask

  task automatic t_onehot();
    logic [7:0] st, d;
    int bad = 0, seen = 0;
    do_reset(1'b1);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      @(negedge clk);
      if ($countones(scan_lines) != 1) bad++;
      seen |= int'(scan_lines);
    end
    check(bad == 0 && seen == 15, "R2 one-hot lines", seen, 15);
    press_key(3'd2, 3'd5, 1'b0);
    bus_read(1'b0, d);
    check(d == exp_code(0, 2, 5), "R2 decoded key byte", int'(d), int'(exp_code(0, 2, 5)));
    press_key(3'd5, 3'd0, 1'b0);
    bus_read(1'b1, st);
    check(st[3:0] == 4'd0, "R2 upper rows unscanned", int'(st[3:0]), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_binary_scan();
    t_debounce_timing();
    t_glitch();
    t_hold_shift();
    t_read_empty();
    t_overflow();
    t_onehot();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule